// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block watches the words of a NAND page as they cross the flash bus, one word per strobe. It folds every set data bit into one Hamming code that covers the whole page. Two 16-bit accumulators do the work. The parity accumulator collects the {word index, bit index} pair of each set bit. The complement-parity accumulator collects the bitwise inverse of that same pair. When a page is programmed, software reads the two values as four code bytes and writes them into the spare area.

When a page is read back, the four stored code bytes must follow the page data directly on the same strobe. The engine then XORs the stored code with the freshly computed one to form a syndrome and sorts it into one of four classes:

- clean;
- a single flipped data bit, with its exact word and bit position;
- a single flipped bit inside the stored code;
- an uncorrectable pattern.

A blank, erased page falls into the last class and shows all ones in both location fields. Software can therefore recognise it as blank. The verdict holds until the parity accumulators are cleared for the next page. Correcting the buffered data is left to software.

Top module: `nand_page_ecc`

## Requirements
- R1: `size_i` selects the page length in bytes, data plus spare: 0 is 528, 1 is 1056, 2 is 2112 and 3 is 4224. The first 512, 1024, 2048 or 4096 bytes are data. The stored code is taken from the strobes that directly follow the data. The remaining spare strobes do not change any output.
- R2: A cycle with `clr_i` high clears the parity value, the complement-parity value, the status and the word position. The outputs read zero on the next cycle.
- R3: During the data phase, every set data bit at word w and bit b XORs {w[11:0], b[3:0]} into `par_o` and XORs the inverse of that pair into `npar_o`. Both outputs show the new value one cycle after the strobe.
- R4: In 8-bit mode the four stored code bytes arrive in this order: parity low byte, parity high byte, complement-parity low byte, complement-parity high byte. In 16-bit mode they arrive as two words: parity, then complement parity.
- R5: `stat_o` is a 3-bit value. Bit 0 means an error was found. Bit 1 means the error is a single bit of the stored code. Bit 2 means multiple errors. A clean page gives 3'b000, and `par_o` then reads 0.
- R6: A single flipped data bit gives `stat_o` = 3'b001. `par_o` then holds {word index[11:0], bit index[3:0]} of that bit, that is, the word address in bits 15:4 and the bit address in bits 3:0.
- R7: A single flipped bit of the stored code gives `stat_o` = 3'b011.
- R8: Any other non-zero syndrome gives `stat_o` = 3'b101, with `par_o` holding the parity syndrome. An erased page, with data and code all ones, gives 3'b101 and `par_o` = 16'hFFFF.
- R9: With `bus16_i` high, each strobe carries 16 data bits. The word index counts 16-bit words, bit indexes run 0 to 15, and all page lengths are halved in words.
- R10: Once the verdict is out, `stat_o`, `par_o` and `npar_o` stay unchanged until the next clear. Spare strobes and strobes beyond the page length have no effect.
- R11: After reset all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears the accumulators and the verdict for a new page |
| size_i | input | 2 | Page size select |
| bus16_i | input | 1 | 1 selects a 16-bit data bus, 0 selects an 8-bit bus |
| stb_i | input | 1 | One bus word transferred in this cycle |
| data_i | input | 16 | Bus word; only bits 7:0 are used in 8-bit mode |
| par_o | output | 16 | Running parity; after the verdict, the error location |
| npar_o | output | 16 | Running complement parity |
| stat_o | output | 3 | Verdict flags |

## Verification
The bench drives inputs on the falling edge. The parity values change one rising edge after a data strobe, so the bench samples them at the next falling edge after the last data word. The verdict needs two rising edges after the final code strobe: one to capture the last code word, one to register the classification. The bench therefore waits one further falling edge after dropping the strobe before it reads `stat_o` and `par_o`. A clear takes effect on the first rising edge, so its result is sampled at the falling edge that ends the pulse. Hold behaviour is checked after the spare words and extra strobes have been streamed.

// File: rtl/nand_page_ecc.sv
module nand_page_ecc #(
  parameter int WA_W = 12,
  parameter int BA_W = 4,
  parameter int DW   = 16,
  parameter int CW   = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic [1:0]           size_i,
  input  logic                 bus16_i,
  input  logic                 stb_i,
  input  logic [DW-1:0]        data_i,
  output logic [WA_W+BA_W-1:0] par_o,
  output logic [WA_W+BA_W-1:0] npar_o,
  output logic [2:0]           stat_o
);
  localparam int PW = WA_W + BA_W;

  logic [CW-1:0] cnt, data_words, total, code_last;
  logic [PW-1:0] acc_p, acc_np, code_p, code_np, syn_p, add_p, add_np, sp, snp;
  logic [DW-1:0] dmask;
  logic [2:0]    stat, cls;
  logic          pend, done, in_data, in_code, live;

  assign data_words = (CW'(512) << size_i) >> bus16_i;
  assign total      = (CW'(528) << size_i) >> bus16_i;
  assign code_last  = data_words + (bus16_i ? CW'(1) : CW'(3));
  assign live       = stb_i && (cnt < total);
  assign in_data    = cnt < data_words;
  assign in_code    = !in_data && (cnt <= code_last);
  assign dmask      = bus16_i ? data_i : {{(DW-8){1'b0}}, data_i[7:0]};

  always_comb begin
    add_p  = '0;
    add_np = '0;
    for (int i = 0; i < DW; i++) begin
      if (dmask[i]) begin
        add_p  = add_p  ^ {cnt[WA_W-1:0], BA_W'(i)};
        add_np = add_np ^ ~{cnt[WA_W-1:0], BA_W'(i)};
      end
    end
  end

  function automatic int unsigned ones(input logic [2*PW-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < 2*PW; i++) n += int'(v[i]);
    return n;
  endfunction

  assign sp  = code_p ^ acc_p;
  assign snp = code_np ^ acc_np;

  always_comb begin
    if (sp == '0 && snp == '0)      cls = 3'b000;
    else if (sp == ~snp)            cls = 3'b001;
    else if (ones({snp, sp}) == 1)  cls = 3'b011;
    else                            cls = 3'b101;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; acc_p <= '0; acc_np <= '0; code_p <= '0; code_np <= '0;
      syn_p <= '0; stat <= '0; pend <= 1'b0; done <= 1'b0;
    end else if (clr_i) begin
      cnt <= '0; acc_p <= '0; acc_np <= '0; code_p <= '0; code_np <= '0;
      syn_p <= '0; stat <= '0; pend <= 1'b0; done <= 1'b0;
    end else begin
      pend <= 1'b0;
      if (live) begin
        cnt <= cnt + 1'b1;
        if (in_data) begin
          acc_p  <= acc_p ^ add_p;
          acc_np <= acc_np ^ add_np;
        end else if (in_code) begin
          if (bus16_i) begin
            if (cnt[0]) code_np <= data_i;
            else        code_p  <= data_i;
          end else begin
            case (cnt[1:0])
              2'd0: code_p[7:0]   <= data_i[7:0];
              2'd1: code_p[15:8]  <= data_i[7:0];
              2'd2: code_np[7:0]  <= data_i[7:0];
              default: code_np[15:8] <= data_i[7:0];
            endcase
          end
          if (cnt == code_last) pend <= 1'b1;
        end
      end
      if (pend) begin
        syn_p <= sp;
        stat  <= cls;
        done  <= 1'b1;
      end
    end
  end

  assign par_o  = done ? syn_p : acc_p;
  assign npar_o = acc_np;
  assign stat_o = stat;

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (par_o == '0 && npar_o == '0 && stat_o == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_i) |=> ($stable(stat_o) && $stable(par_o) && $stable(npar_o)));
  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !clr_i && cnt >= total) |=> ($stable(par_o) && $stable(npar_o) && $stable(stat_o)));
  // R5
  flag_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[2:1] != 2'b00) |-> (stat_o[0] && $onehot0(stat_o[2:1])));
  // R3
  code_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !clr_i && !in_data) |=> $stable(npar_o));
endmodule

// File: tb/nand_page_ecc_tb.sv
module nand_page_ecc_tb;
  logic        clk = 0, rst_n = 0, clr_i = 0, bus16_i = 0, stb_i = 0;
  logic [1:0]  size_i = 0;
  logic [15:0] data_i = 0, par_o, npar_o;
  logic [2:0]  stat_o;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  nand_page_ecc u_dut (.clk(clk), .rst_n(rst_n), .clr_i(clr_i), .size_i(size_i),
    .bus16_i(bus16_i), .stb_i(stb_i), .data_i(data_i), .par_o(par_o),
    .npar_o(npar_o), .stat_o(stat_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d);
    @(negedge clk); stb_i = 1; data_i = d;
  endtask

  task automatic idle();
    @(negedge clk); stb_i = 0; data_i = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); stb_i = 0; clr_i = 1;
    @(negedge clk); clr_i = 0;
  endtask

  function automatic logic [15:0] gen(input int seed, input int w, input int wide);
    int v = w * 73 + seed * 29 + (w >> 3) * 5 + (w * w) % 251;
    return wide ? 16'(v * 257 + w) : {8'h00, 8'(v)};
  endfunction

  // kind: 0 clean, 1 data flip, 2 code flip, 3 double data flip, 4 erased
  task automatic run_page(input int mode, input int wide, input int seed, input int kind,
                          input int fa, input int fb, input int fc, input string tag);
    int nw = (512 << mode) >> wide;
    int nt = (528 << mode) >> wide;
    int nb = wide ? 16 : 8;
    int ncode = wide ? 2 : 4;
    logic [15:0] cp = 0, cnp = 0, rp = 0, rnp = 0, sp, snp, d, rd, exp_par;
    logic [2:0] exp_st;
    size_i = 2'(mode); bus16_i = wide[0];
    pulse_clr();
    for (int w = 0; w < nw; w++) begin
      d = (kind == 4) ? (wide ? 16'hFFFF : 16'h00FF) : gen(seed, w, wide);
      rd = d;
      if ((kind == 1 || kind == 3) && w == fa) rd[fb] = ~rd[fb];
      if (kind == 3 && w == fa + 1) rd[fb] = ~rd[fb];
      for (int b = 0; b < nb; b++) begin
        if (d[b])  begin cp  ^= {12'(w), 4'(b)}; cnp ^= ~{12'(w), 4'(b)}; end
        if (rd[b]) begin rp  ^= {12'(w), 4'(b)}; rnp ^= ~{12'(w), 4'(b)}; end
      end
      put(rd);
    end
    idle();
    check(par_o == rp, {tag, " R3 parity"}, 32'(par_o), 32'(rp));
    check(npar_o == rnp, {tag, " R3 complement parity"}, 32'(npar_o), 32'(rnp));
    sp = cp; snp = cnp;
    if (kind == 4) begin sp = 16'hFFFF; snp = 16'hFFFF; end
    if (kind == 2) begin
      if (fc < 16) sp[fc] = ~sp[fc]; else snp[fc-16] = ~snp[fc-16];
    end
    // R4 code order
    if (wide) begin put(sp); put(snp); end
    else begin put({8'h0, sp[7:0]}); put({8'h0, sp[15:8]}); put({8'h0, snp[7:0]}); put({8'h0, snp[15:8]}); end
    idle();
    @(negedge clk);
    case (kind)
      0: begin exp_st = 3'b000; exp_par = 16'h0; end
      1: begin exp_st = 3'b001; exp_par = {12'(fa), 4'(fb)}; end
      2: begin exp_st = 3'b011; exp_par = (fc < 16) ? 16'(1 << fc) : 16'h0; end
      3: begin exp_st = 3'b101; exp_par = {12'(fa) ^ 12'(fa + 1), 4'h0}; end
      default: begin exp_st = 3'b101; exp_par = 16'hFFFF; end
    endcase
    check(stat_o == exp_st, {tag, " R5 R6 R7 R8 status"}, 32'(stat_o), 32'(exp_st));
    check(par_o == exp_par, {tag, " R6 R8 location"}, 32'(par_o), 32'(exp_par));
    for (int k = 0; k < nt - nw - ncode + 6; k++) put(16'(k * 4099 + 17));
    idle();
    check(stat_o == exp_st && par_o == exp_par && npar_o == rnp, {tag, " R10 hold"},
          {13'h0, stat_o, par_o}, {13'h0, exp_st, exp_par});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(par_o == 0 && npar_o == 0 && stat_o == 0, "R11 reset", {13'h0, stat_o, par_o}, 0);
    rst_n = 1;
    run_page(0, 0, 1, 0, 0, 0, 0, "R5 clean m0");
    for (int b = 0; b < 8; b++) run_page(0, 0, b + 2, 1, (b * 61 + 3) % 512, b, 0, "R6 flip m0");
    for (int c = 0; c < 32; c++) run_page(0, 0, 9, 2, 0, 0, c, "R7 code flip m0");
    run_page(0, 0, 4, 3, 100, 5, 0, "R8 double m0");
    run_page(0, 0, 0, 4, 0, 0, 0, "R8 erased m0");
    for (int m = 1; m < 4; m++) begin
      run_page(m, 0, m, 0, 0, 0, 0, "R1 clean");
      run_page(m, 0, m + 7, 1, (512 << m) - 1, 7, 0, "R1 last word");
    end
    run_page(0, 1, 3, 0, 0, 0, 0, "R9 clean w16");
    for (int b = 0; b < 16; b++) run_page(0, 1, b, 1, 255 - b * 9, b, 0, "R9 flip w16");
    run_page(0, 1, 5, 2, 0, 0, 31, "R9 R7 code w16");
    run_page(0, 1, 0, 4, 0, 0, 0, "R9 R8 erased w16");
    run_page(3, 1, 6, 1, 2047, 15, 0, "R9 R1 last w16");
    pulse_clr();
    check(par_o == 0 && npar_o == 0 && stat_o == 0, "R2 clear", {13'h0, stat_o, par_o}, 0);
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule